// File: doc/BRIEF.md
# Free-Running Compare/Capture Timer

This block is a free-running up-counter with one compare channel and one capture channel. A prescaler divides the system clock down to a count-enable pulse. The counter advances once per pulse and runs through every value up to all ones, then wraps to zero. Reaching the compare value never clears or stops the count. When the count arrives at the compare value, the block can raise a one-cycle interrupt pulse and can invert a toggle output. Either response is enabled separately. A wrap sets a sticky overflow flag, which software clears.

An external trigger input goes through two synchronizing flops. An edge of the selected polarity on that input copies the running count into a capture register. Software reaches the block through a single-cycle write port and a combinational read port. The count is read from a buffer that the counter refreshes every clock, so the whole word read is always from one instant. A compare rewrite is guarded: the first count step after a write to the compare register can never produce a match. This keeps a change of compare value from causing a stray toggle or interrupt.

Top module: `cmp_cap_timer`

## Requirements
- R1: After reset the counter, compare, capture and count buffer read zero. The control word also reads zero, so the divide select is 0, capture is off, both enables are off, and the toggle level and overflow flag are 0. `tog_o` and `irq_o` are low.
- R2: The prescaler starts at zero after reset and steps every clock. The counter advances by exactly one every 4, 16, 64 or 256 clocks for divide select 0, 1, 2 or 3 (control bits [1:0]). The first step comes after one full period.
- R3: The counter is never cleared by a compare match. From the all-ones value it wraps to zero on its next step.
- R4: When interrupt enable (control bit 4) is set, `irq_o` is high for exactly one clock. This happens in the cycle after the step that brings the counter to the compare value.
- R5: When toggle enable (control bit 5) is set, that same step inverts `tog_o`. The present level of `tog_o` reads back in control bit 8.
- R6: The overflow flag (control bit 9) is set by a wrap and held. A control write with bit 9 at 0 clears it, and a control write with bit 9 at 1 leaves it unchanged. A wrap in the same cycle as a clearing write leaves the flag set.
- R7: Capture mode sits in control bits [3:2]: 0 off, 1 rising, 2 falling, 3 both edges. A selected edge on `trig_i` loads the capture register with the count held just before the third clock edge after the change. In mode 0, trigger edges leave the capture register unchanged.
- R8: A read of address 3 returns the count buffer, which holds the counter value from one clock earlier, zero-extended.
- R9: After a write to the compare register, the first count step produces no interrupt and no toggle, whatever the new compare value.
- R10: The address map is: 0 control, 1 compare (read/write), 2 capture (read only), 3 count buffer (read only). Writes to 2 and 3 have no effect. Compare, capture and count read back zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, synchronously released upstream |
| wr_en_i | input | 1 | Register write strobe, one clock per write |
| addr_i | input | 2 | Register address for write and read |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| trig_i | input | 1 | Asynchronous capture trigger |
| tog_o | output | 1 | Compare toggle output |
| irq_o | output | 1 | Compare-match interrupt pulse |

## Verification
The properties assume that the register port is driven only with single-cycle write strobes. They also assume that the trigger is either asynchronous to the clock or held for at least one clock, because the capture path only sees levels after its synchronizer. The stimulus changes every input on the falling clock edge and holds each write strobe for one cycle. Trigger levels are held for several clocks, so no edge falls inside a synchronizer window.

The properties also rely on the prescaler never giving two count steps on consecutive clocks. This holds for every divide select, including the moment the select changes. The stimulus sometimes rewrites the compare value while the enables are still on, to exercise the guard. The bench is built with a 12-bit counter, so that several wraps fit in one run.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CAP  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd3;

  localparam int BIT_IRQ_EN = 4;
  localparam int BIT_TOG_EN = 5;
  localparam int BIT_OUT    = 8;
  localparam int BIT_OVF    = 9;

  typedef enum logic [1:0] {
    CAP_OFF  = 2'd0,
    CAP_RISE = 2'd1,
    CAP_FALL = 2'd2,
    CAP_BOTH = 2'd3
  } cap_mode_e;
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int N_SEL = 1 << SEL_W;

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] mask [N_SEL];

  // R2: ratio 4^(sel+1) -> low 2*(sel+1) bits all ones
  for (genvar g = 0; g < N_SEL; g++) begin : g_mask
    assign mask[g] = DIV_W'((1 << (2 * (g + 1))) - 1);
  end

  always_comb begin
    div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  assign tick_o = &(div_q | ~mask[sel_i]);
endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         trig_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] cap_o
);
  import cct_pkg::*;

  logic         s0_q, s1_q, prev_q;
  logic [W-1:0] cap_q, cap_d;
  logic         rise, fall, take;

  always_comb begin
    rise = s1_q & ~prev_q;
    fall = ~s1_q & prev_q;
    unique case (cap_mode_e'(mode_i))
      CAP_RISE: take = rise;
      CAP_FALL: take = fall;
      CAP_BOTH: take = rise | fall;
      default:  take = 1'b0;           // R7: off
    endcase
    cap_d = take ? cnt_i : cap_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q   <= 1'b0;
      s1_q   <= 1'b0;
      prev_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      s0_q   <= trig_i;
      s1_q   <= s0_q;
      prev_q <= s1_q;
      cap_q  <= cap_d;
    end
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/cct_core.sv
module cct_core #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] cmp_wdata_i,
  input  logic         irq_en_i,
  input  logic         tog_en_i,
  input  logic         ovf_clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cmp_o,
  output logic         ovf_o,
  output logic         out_o,
  output logic         irq_o
);
  logic [W-1:0] cnt_q, cnt_d, cmp_q, cmp_d, cnt_inc;
  logic         ovf_q, ovf_d, out_q, out_d, irq_q, irq_d, guard_q, guard_d;
  logic         hit;

  always_comb begin
    cnt_inc = cnt_q + W'(1);
    hit     = tick_i && (cnt_inc == cmp_q) && !guard_q;  // R9 guard
    cnt_d   = cnt_q;
    cmp_d   = cmp_q;
    ovf_d   = ovf_q;
    out_d   = out_q;
    irq_d   = 1'b0;
    guard_d = guard_q;
    if (ovf_clr_i) ovf_d = 1'b0;
    if (tick_i) begin
      cnt_d   = cnt_inc;                 // R3: free-run, wraps
      guard_d = 1'b0;
      if (&cnt_q) ovf_d = 1'b1;          // R6: set beats clear
      if (hit) begin
        irq_d = irq_en_i;                // R4
        if (tog_en_i) out_d = ~out_q;    // R5
      end
    end
    if (cmp_wr_i) begin
      cmp_d   = cmp_wdata_i;
      guard_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      cmp_q   <= '0;
      ovf_q   <= 1'b0;
      out_q   <= 1'b0;
      irq_q   <= 1'b0;
      guard_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      cmp_q   <= cmp_d;
      ovf_q   <= ovf_d;
      out_q   <= out_d;
      irq_q   <= irq_d;
      guard_q <= guard_d;
    end
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;
  assign ovf_o = ovf_q;
  assign out_o = out_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/cmp_cap_timer.sv
module cmp_cap_timer #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  input  logic        trig_i,
  output logic        tog_o,
  output logic        irq_o
);
  import cct_pkg::*;

  localparam int SEL_W = 2;

  logic [SEL_W-1:0] sel_q, sel_d;
  logic [1:0]       mode_q, mode_d;
  logic             irq_en_q, irq_en_d, tog_en_q, tog_en_d;
  logic [CNT_W-1:0] buf_q, cnt_q, cmp_q, cap_q;
  logic             ctrl_wr, cmp_wr, ovf_clr, tick, ovf_q, out_q, irq_q;

  // R10: address decode
  always_comb begin
    ctrl_wr  = wr_en_i && (addr_i == ADDR_CTRL);
    cmp_wr   = wr_en_i && (addr_i == ADDR_CMP);
    ovf_clr  = ctrl_wr && !wdata_i[BIT_OVF];
    sel_d    = ctrl_wr ? wdata_i[SEL_W-1:0] : sel_q;
    mode_d   = ctrl_wr ? wdata_i[3:2] : mode_q;
    irq_en_d = ctrl_wr ? wdata_i[BIT_IRQ_EN] : irq_en_q;
    tog_en_d = ctrl_wr ? wdata_i[BIT_TOG_EN] : tog_en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= '0;
      mode_q   <= '0;
      irq_en_q <= 1'b0;
      tog_en_q <= 1'b0;
      buf_q    <= '0;
    end else begin
      sel_q    <= sel_d;
      mode_q   <= mode_d;
      irq_en_q <= irq_en_d;
      tog_en_q <= tog_en_d;
      buf_q    <= cnt_q;                 // R8: coherent snapshot
    end
  end

  cct_prescaler #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (sel_q),
    .tick_o(tick)
  );

  cct_core #(.W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .cmp_wr_i   (cmp_wr),
    .cmp_wdata_i(wdata_i[CNT_W-1:0]),
    .irq_en_i   (irq_en_q),
    .tog_en_i   (tog_en_q),
    .ovf_clr_i  (ovf_clr),
    .cnt_o      (cnt_q),
    .cmp_o      (cmp_q),
    .ovf_o      (ovf_q),
    .out_o      (out_q),
    .irq_o      (irq_q)
  );

  cct_capture #(.W(CNT_W)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(trig_i),
    .mode_i(mode_q),
    .cnt_i (cnt_q),
    .cap_o (cap_q)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = {6'd0, ovf_q, out_q, 2'd0, tog_en_q, irq_en_q, mode_q, sel_q};
      ADDR_CMP:  rdata_o = DATA_W'(cmp_q);
      ADDR_CAP:  rdata_o = DATA_W'(cap_q);
      default:   rdata_o = DATA_W'(buf_q);
    endcase
  end

  assign tog_o = out_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         irq_o,
  input logic         tog_o,
  input logic [W-1:0] cnt,
  input logic         ovf,
  input logic         cmp_wr,
  input logic [W-1:0] cap,
  input logic [1:0]   cap_mode
);
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != $past(cnt)) |-> (cnt == W'($past(cnt) + W'(1))));

  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&$past(cnt)) && !(&cnt)) |-> (cnt == '0));

  assert_irq_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_tog_on_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tog_o != $past(tog_o)) |-> (cnt != $past(cnt)));

  assert_ovf_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf) |-> ((&$past(cnt)) && (cnt == '0)));

  assert_cap_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap != $past(cap)) |-> ($past(cap_mode) != 2'd0));

  assert_cmp_guard_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_wr |=> ##1 !irq_o);
endmodule

bind cmp_cap_timer cct_checker #(.W(CNT_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .tog_o   (tog_o),
  .cnt     (cnt_q),
  .ovf     (ovf_q),
  .cmp_wr  (cmp_wr),
  .cap     (cap_q),
  .cap_mode(mode_q)
);

// File: tb/cmp_cap_timer_tb_top.sv
`timescale 1ns/1ps
module cmp_cap_timer_tb_top;
  localparam int CW = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        trig = 1'b0;
  logic        tog, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit live  = 1'b0;

  always #2.5 clk = ~clk;

  cmp_cap_timer #(.CNT_W(CW), .DIV_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .trig_i(trig), .tog_o(tog), .irq_o(irq)
  );

  // reference state, built from the requirements
  logic [7:0]    m_div;
  logic [1:0]    m_sel, m_mode;
  logic          m_irqen, m_togen, m_ovf, m_out, m_irq, m_guard;
  logic [CW-1:0] m_cnt, m_cmp, m_cap, m_buf;
  logic [2:0]    m_sync;

  function automatic logic tick_f(logic [7:0] d, logic [1:0] s);
    logic [7:0] mk;
    mk = 8'((1 << (2 * (int'(s) + 1))) - 1);
    return &(d | ~mk);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div <= '0; m_sel <= '0; m_mode <= '0; m_irqen <= 1'b0; m_togen <= 1'b0;
      m_ovf <= 1'b0; m_out <= 1'b0; m_irq <= 1'b0; m_guard <= 1'b0;
      m_cnt <= '0; m_cmp <= '0; m_cap <= '0; m_buf <= '0; m_sync <= '0;
    end else begin
      logic t, ov, gd, ou, ir, rise, fall;
      t  = tick_f(m_div, m_sel);
      ov = m_ovf; gd = m_guard; ou = m_out; ir = 1'b0;
      if (wr_en && addr == 2'd0 && !wdata[9]) ov = 1'b0;
      if (t) begin
        if (&m_cnt) ov = 1'b1;
        gd = 1'b0;
        if (CW'(m_cnt + 1'b1) == m_cmp && !m_guard) begin
          ir = m_irqen;
          if (m_togen) ou = ~m_out;
        end
        m_cnt <= CW'(m_cnt + 1'b1);
      end
      if (wr_en && addr == 2'd1) begin gd = 1'b1; m_cmp <= wdata[CW-1:0]; end
      if (wr_en && addr == 2'd0) begin
        m_sel <= wdata[1:0]; m_mode <= wdata[3:2];
        m_irqen <= wdata[4]; m_togen <= wdata[5];
      end
      rise = m_sync[1] & ~m_sync[2];
      fall = ~m_sync[1] & m_sync[2];
      if ((m_mode == 2'd1 && rise) || (m_mode == 2'd2 && fall) ||
          (m_mode == 2'd3 && (rise | fall))) m_cap <= m_cnt;
      m_sync <= {m_sync[1:0], trig};
      m_ovf <= ov; m_guard <= gd; m_out <= ou; m_irq <= ir;
      m_div <= m_div + 8'd1;
      m_buf <= m_cnt;
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0:    return {6'd0, m_ovf, m_out, 2'd0, m_togen, m_irqen, m_mode, m_sel};
      2'd1:    return 16'(m_cmp);
      2'd2:    return 16'(m_cap);
      default: return 16'(m_buf);
    endcase
  endfunction

  // R4 and R5 at every clock
  always @(negedge clk) begin
    if (live) begin
      check("R4 irq", {15'd0, irq}, {15'd0, m_irq});
      check("R5 tog", {15'd0, tog}, {15'd0, m_out});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, string req);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdata, exp_rd(a));
  endtask

  task automatic rd_val(logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #1;
    v = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v0, v1;
    int pulses;
    void'($urandom(32'd7411));
    idle(3);
    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); addr = 2'(a); #1;
      check("R1 reset read", rdata, 16'd0);
    end
    check("R1 tog", {15'd0, tog}, 16'd0);
    check("R1 irq", {15'd0, irq}, 16'd0);
    @(negedge clk); rst_n = 1'b1;
    live = 1'b1;

    // R2: divide by 16 gives 4 steps in 64 clocks
    wr(2'd0, 16'h0001);
    rd_val(2'd3, v0);
    idle(63);
    rd_val(2'd3, v1);
    check("R2 step rate", v1 - v0, 16'd4);
    rd(2'd3, "R8 count buffer");

    // R4/R5: compare ahead, sel 0, both enabled
    wr(2'd0, 16'h0030);
    wr(2'd1, 16'(m_cnt + CW'(6)));
    idle(40);
    rd(2'd0, "R5 level readback");

    // R9: rewrite to next value with enables on: no pulse
    wr(2'd1, 16'(m_cnt + CW'(1)));
    pulses = 0;
    repeat (8) begin @(negedge clk); if (irq) pulses++; end
    check("R9 no spurious irq", 16'(pulses), 16'd0);

    // R3/R6: run past a wrap
    idle(17000);
    rd(2'd0, "R6 overflow set");
    check("R6 flag high", {15'd0, rdata[9]}, 16'd1);
    wr(2'd0, 16'h0230);                    // bit 9 = 1 keeps it
    rd(2'd0, "R6 keep on bit9 one");
    wr(2'd0, 16'h0030);                    // clear
    rd(2'd0, "R6 cleared");
    rd(2'd3, "R3 wrapped count");

    // R7: modes with a slow counter
    wr(2'd0, 16'h0007);                    // rising, div 256
    @(negedge clk); trig = 1'b1; idle(5);
    rd(2'd2, "R7 rising capture");
    wr(2'd0, 16'h0003);                    // off
    @(negedge clk); trig = 1'b0; idle(300);
    @(negedge clk); trig = 1'b1; idle(5);
    rd(2'd2, "R7 off ignores edges");
    wr(2'd0, 16'h000B);                    // falling
    idle(300);
    @(negedge clk); trig = 1'b0; idle(5);
    rd(2'd2, "R7 falling capture");

    // R10: writes to read-only addresses ignored
    wr(2'd2, 16'hFFFF);
    wr(2'd3, 16'hFFFF);
    rd(2'd2, "R10 capture read-only");
    rd(2'd3, "R10 count read-only");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int op;
      idle(1 + int'($urandom % 10));
      op = int'($urandom % 100);
      if (op < 35) begin
        @(negedge clk); trig = ~trig; idle(4);
      end else if (op < 50) begin
        logic [15:0] d;
        d = 16'($urandom) & 16'h023F;
        if (($urandom % 8) < 6) d[1:0] = 2'd0;
        wr(2'd0, d);
      end else if (op < 60) begin
        if ($urandom % 2) wr(2'd0, {6'd0, 1'b1, 3'd0, 2'b00, m_mode, m_sel});
        wr(2'd1, 16'($urandom));
      end else begin
        logic [1:0] a;
        a = 2'($urandom);
        case (a)
          2'd0: rd(a, "R6 ctrl random");
          2'd1: rd(a, "R10 compare random");
          2'd2: rd(a, "R7 capture random");
          default: rd(a, "R8 count random");
        endcase
      end
    end

    live = 1'b0;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule